// File: doc/BRIEF.md
# Two-Wire Bus Arbitration Monitor

This block sits beside the bit engine of a two-wire (I2C-style) master. On every rising edge of the clock line it compares the level the local master is driving onto the data line with the level actually seen on it. A master that releases the data line (drives a one) while the line reads zero has been outvoted by another master. In that case the block withdraws both the data and clock drive enables in the very cycle the conflict is seen.

After a loss, the block reports whether it happened while the address byte was being sent or during a data byte. A loss in the address byte does not end the transfer for this node. The block keeps collecting the winning master's address and read/write bit, then compares the address with the node's own address and with the general-call address. The outcome is an 8-bit status code and a mode indication. A node that is not addressed either goes quiet as a slave that was not addressed, or waits for the bus to become free and then asks for a new START. A control input selects which.

Byte shifting, clock generation and any register access are left to the surrounding logic. That logic supplies the current bit index (0 to 7 for the byte bits, most significant bit first, and 8 for the acknowledge slot) and a flag that marks the address byte.

Top module: `arb_watch`

## Requirements
- R1: After reset the mode output is 0 (master), status is 0xF8, `arb_lost`, `lost_in_addr` and `start_req` are 0, and `sda_oe`/`scl_oe` follow `sda_oe_req`/`scl_oe_req`.
- R2: When the sampled data line equals the level the local master drives at each clock-line rising edge, no loss is flagged, the mode stays 0 and the drive enables keep following their requests.
- R3: When `drv_sda`=1 and `sda_in`=0 at a clock-line rising edge during an active, unmasked bit, `sda_oe` and `scl_oe` are 0 in that same clock cycle, and they remain 0 until a STOP is seen.
- R4: No comparison takes place in the acknowledge slot (`bit_idx`=8) or while `drv_active`=0. A mismatch there leaves `arb_lost` at 0 and the enables unchanged.
- R5: A loss with `addr_phase`=0 sets `arb_lost`=1, `lost_in_addr`=0 and status 0x38 on the next clock.
- R6: After a loss in the address byte, if the winning 7-bit address equals `own_addr` and the read/write bit is 0 (write), the status becomes 0x68, the mode becomes 2 (slave receiver) and `lost_in_addr`=1.
- R7: After a loss in the address byte, an address of 0 with a write bit gives status 0x78 and mode 2 when `gc_en`=1. With `gc_en`=0 the same address counts as not addressed.
- R8: After a loss in the address byte, an own-address match with a read bit (1) gives status 0xB0 and mode 3 (slave transmitter).
- R9: A loss that does not end in self-addressing gives status 0x38. The mode becomes 4 (not addressed) when `retry_en`=0 and 5 (waiting for bus free) when `retry_en`=1. From mode 5, a STOP raises `start_req` for exactly one cycle, on the clock after the STOP is registered.
- R10: A STOP (the data line rising while the clock line is high) returns the block to mode 0 with status 0xF8 and clears `arb_lost` and `lost_in_addr`.
- R11: A loss on the read/write bit itself (bit index 7 of the address byte) resolves the address match on that same edge, using the sampled line level as the direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Synchronized clock-line level |
| sda_in | input | 1 | Synchronized data-line level |
| drv_active | input | 1 | Local master is transmitting the current bit |
| drv_sda | input | 1 | Level the local master puts on the data line (1 = released) |
| bit_idx | input | 4 | Bit position: 0..7 byte bits MSB first, 8 acknowledge |
| addr_phase | input | 1 | Current byte is the address byte |
| own_addr | input | 7 | Node's own slave address |
| gc_en | input | 1 | Respond to the general-call address |
| retry_en | input | 1 | 1: wait for bus free and request START; 0: not-addressed slave |
| sda_oe_req | input | 1 | Master's request to pull the data line |
| scl_oe_req | input | 1 | Master's request to pull the clock line |
| sda_oe | output | 1 | Gated data-line pull enable |
| scl_oe | output | 1 | Gated clock-line pull enable |
| arb_lost | output | 1 | Arbitration lost since the last STOP |
| lost_in_addr | output | 1 | The loss happened in the address byte |
| status | output | 8 | Status code |
| mode | output | 3 | 0 master, 1 collecting address, 2 slave rx, 3 slave tx, 4 not addressed, 5 waiting for bus free |
| start_req | output | 1 | One-cycle request to issue a START |

## Verification
If the mode register took a wrong value, the fault would appear at once, because the drive enables come straight from it. A node that wrongly believes it owns the bus would show non-zero enables after a loss. A node that wrongly believes it lost would block its master's requests. Wrong address capture or wrong match logic stays hidden until the edge of the read/write bit and then shows as a wrong status code one clock later. The bench therefore checks the status and mode after every address byte, and checks the enables in the very cycle of each conflicting bit.

// File: rtl/arbw_pkg.sv
// Shared types and status codes for the arbitration monitor.
package arbw_pkg;

    // Operating mode of the node as seen by the arbitration monitor.
    typedef enum logic [2:0] {
        MD_MASTER    = 3'd0,
        MD_COLLECT   = 3'd1,
        MD_SLV_RX    = 3'd2,
        MD_SLV_TX    = 3'd3,
        MD_UNADDR    = 3'd4,
        MD_WAIT_FREE = 3'd5
    } arbw_mode_e;

    localparam int          STAT_W     = 8;
    localparam logic [7:0]  ST_NONE    = 8'hF8;
    localparam logic [7:0]  ST_LOST    = 8'h38;
    localparam logic [7:0]  ST_SR_OWN  = 8'h68;
    localparam logic [7:0]  ST_SR_GC   = 8'h78;
    localparam logic [7:0]  ST_ST_OWN  = 8'hB0;

endpackage

// File: rtl/arbw_edges.sv
// Line event detector.
// Detects the clock-line rising edge and STOP/START conditions from the
// already synchronized line levels. Assumes both lines idle high.
module arbw_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic bus_stop,
    output logic bus_start
);

    logic scl_q;
    logic sda_q;

    // Hold the previous line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
        end
    end

    // Decode the line events from the current and previous levels.
    always_comb begin
        scl_rise  = scl_in & ~scl_q;
        bus_stop  = scl_in & scl_q & sda_in & ~sda_q;
        bus_start = scl_in & scl_q & ~sda_in & sda_q;
    end

endmodule

// File: rtl/arbw_compare.sv
// Bit comparator and address capture.
// Flags a mismatch when the local master releases the data line but the
// line samples low on a clock rising edge. Masks the acknowledge slot and
// bits the master does not drive. Also shifts in the address byte seen on
// the line, whoever sent it.
module arbw_compare #(
    parameter int BIT_W   = 4,
    parameter int ADDR_W  = 7,
    parameter int ACK_POS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              sda_in,
    input  logic              drv_active,
    input  logic              drv_sda,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic              addr_phase,
    input  logic              is_owner,
    output logic              mismatch,
    output logic              byte_done,
    output logic [ADDR_W-1:0] win_addr,
    output logic              win_rw
);

    localparam logic [BIT_W-1:0] ACK_IDX = BIT_W'(ACK_POS);
    localparam logic [BIT_W-1:0] RW_IDX  = BIT_W'(ADDR_W);

    logic [ADDR_W-1:0] addr_sh;
    logic              addr_bit;

    // Qualify the compare and detect the end of the address byte.
    always_comb begin
        mismatch  = scl_rise & is_owner & drv_active & drv_sda & ~sda_in
                    & (bit_idx != ACK_IDX);
        addr_bit  = scl_rise & addr_phase & (bit_idx < RW_IDX);
        byte_done = scl_rise & addr_phase & (bit_idx == RW_IDX);
        win_addr  = addr_sh;
        win_rw    = sda_in;
    end

    // Shift the address bits seen on the line, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_sh <= '0;
        end else if (addr_bit) begin
            addr_sh <= {addr_sh[ADDR_W-2:0], sda_in};
        end
    end

endmodule

// File: rtl/arbw_decide.sv
// Arbitration outcome state machine.
// Tracks ownership, records where a loss happened and resolves the
// address match after an address-byte loss. Returns to master on STOP.
module arbw_decide
    import arbw_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mismatch,
    input  logic              addr_phase,
    input  logic              byte_done,
    input  logic [ADDR_W-1:0] win_addr,
    input  logic              win_rw,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic              retry_en,
    input  logic              bus_stop,
    output arbw_mode_e        mode_q,
    output logic [STAT_W-1:0] status_q,
    output logic              lost_q,
    output logic              lost_addr_q,
    output logic              start_q
);

    logic              own_hit;
    logic              gc_hit;
    arbw_mode_e        res_mode;
    logic [STAT_W-1:0] res_status;
    arbw_mode_e        idle_mode;

    // Resolve the address match for the byte that just completed.
    always_comb begin
        own_hit   = (win_addr == own_addr);
        gc_hit    = gc_en & (win_addr == '0) & ~win_rw;
        idle_mode = retry_en ? MD_WAIT_FREE : MD_UNADDR;
        if (own_hit && !win_rw) begin
            res_mode   = MD_SLV_RX;
            res_status = ST_SR_OWN;
        end else if (own_hit) begin
            res_mode   = MD_SLV_TX;
            res_status = ST_ST_OWN;
        end else if (gc_hit) begin
            res_mode   = MD_SLV_RX;
            res_status = ST_SR_GC;
        end else begin
            res_mode   = idle_mode;
            res_status = ST_LOST;
        end
    end

    // Advance mode, status and loss flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= MD_MASTER;
            status_q    <= ST_NONE;
            lost_q      <= 1'b0;
            lost_addr_q <= 1'b0;
            start_q     <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (bus_stop) begin
                start_q     <= (mode_q == MD_WAIT_FREE);
                mode_q      <= MD_MASTER;
                status_q    <= ST_NONE;
                lost_q      <= 1'b0;
                lost_addr_q <= 1'b0;
            end else begin
                case (mode_q)
                    MD_MASTER: begin
                        if (mismatch) begin
                            lost_q      <= 1'b1;
                            lost_addr_q <= addr_phase;
                            if (!addr_phase) begin
                                mode_q   <= idle_mode;
                                status_q <= ST_LOST;
                            end else if (byte_done) begin
                                mode_q   <= res_mode;
                                status_q <= res_status;
                            end else begin
                                mode_q   <= MD_COLLECT;
                            end
                        end
                    end
                    MD_COLLECT: begin
                        if (byte_done) begin
                            mode_q   <= res_mode;
                            status_q <= res_status;
                        end
                    end
                    default: begin
                        mode_q <= mode_q;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/arb_watch.sv
// Top of the two-wire arbitration monitor.
// Gates the master's line drive enables by bus ownership. Drops them in the
// same cycle a conflicting bit is sampled. Reports the outcome of a lost
// arbitration. Assumes scl_in/sda_in are already synchronized to clk.
module arb_watch
    import arbw_pkg::*;
#(
    parameter int BIT_W   = 4,
    parameter int ADDR_W  = 7,
    parameter int ACK_POS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              drv_active,
    input  logic              drv_sda,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic              addr_phase,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic              retry_en,
    input  logic              sda_oe_req,
    input  logic              scl_oe_req,
    output logic              sda_oe,
    output logic              scl_oe,
    output logic              arb_lost,
    output logic              lost_in_addr,
    output logic [7:0]        status,
    output logic [2:0]        mode,
    output logic              start_req
);

    logic              scl_rise;
    logic              bus_stop;
    logic              bus_start;
    logic              mismatch;
    logic              byte_done;
    logic [ADDR_W-1:0] win_addr;
    logic              win_rw;
    logic              is_owner;
    arbw_mode_e        mode_q;
    logic [STAT_W-1:0] status_q;

    arbw_edges u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_rise  (scl_rise),
        .bus_stop  (bus_stop),
        .bus_start (bus_start)
    );

    arbw_compare #(
        .BIT_W   (BIT_W),
        .ADDR_W  (ADDR_W),
        .ACK_POS (ACK_POS)
    ) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (scl_rise),
        .sda_in     (sda_in),
        .drv_active (drv_active),
        .drv_sda    (drv_sda),
        .bit_idx    (bit_idx),
        .addr_phase (addr_phase),
        .is_owner   (is_owner),
        .mismatch   (mismatch),
        .byte_done  (byte_done),
        .win_addr   (win_addr),
        .win_rw     (win_rw)
    );

    arbw_decide #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .mismatch    (mismatch),
        .addr_phase  (addr_phase),
        .byte_done   (byte_done),
        .win_addr    (win_addr),
        .win_rw      (win_rw),
        .own_addr    (own_addr),
        .gc_en       (gc_en),
        .retry_en    (retry_en),
        .bus_stop    (bus_stop),
        .mode_q      (mode_q),
        .status_q    (status_q),
        .lost_q      (arb_lost),
        .lost_addr_q (lost_in_addr),
        .start_q     (start_req)
    );

    // Gate the drive enables by ownership and by the live compare result.
    always_comb begin
        is_owner = (mode_q == MD_MASTER);
        sda_oe   = sda_oe_req & is_owner & ~mismatch;
        scl_oe   = scl_oe_req & is_owner & ~mismatch;
        status   = status_q;
        mode     = mode_q;
    end

    // A START seen on the line needs no action here; the bit engine owns it.
    logic unused_ok;
    always_comb unused_ok = bus_start;

endmodule

// File: rtl/arbw_chk.sv
// Property checker for arb_watch, attached with bind.
module arbw_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       scl_oe,
    input logic       arb_lost,
    input logic       lost_in_addr,
    input logic [7:0] status,
    input logic [2:0] mode,
    input logic       start_req
);

    AST_RELEASE_AFTER_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> (!sda_oe && !scl_oe)); // R3

    AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0) |-> (status == 8'hF8 && !arb_lost)); // R10

    AST_SLV_RX_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2) |-> ((status == 8'h68 || status == 8'h78) && lost_in_addr)); // R6

    AST_SLV_TX_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3) |-> (status == 8'hB0 && lost_in_addr)); // R8

    AST_START_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_req) |-> ($past(mode) == 3'd5)); // R9

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> !start_req); // R9

    AST_DATA_LOSS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && !lost_in_addr) |-> (status == 8'h38)); // R5

endmodule

bind arb_watch arbw_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sda_oe       (sda_oe),
    .scl_oe       (scl_oe),
    .arb_lost     (arb_lost),
    .lost_in_addr (lost_in_addr),
    .status       (status),
    .mode         (mode),
    .start_req    (start_req)
);

// File: tb/sim_arb_watch.sv
module sim_arb_watch;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl_in, sda_in, drv_active, drv_sda, addr_phase;
    logic [3:0] bit_idx;
    logic [6:0] own_addr;
    logic       gc_en, retry_en, sda_oe_req, scl_oe_req;
    logic       sda_oe, scl_oe, arb_lost, lost_in_addr, start_req;
    logic [7:0] status;
    logic [2:0] mode;
    logic [8:0] oe_log;
    int         n_tests = 0;
    int         n_fail  = 0;

    always #5 clk = ~clk;

    arb_watch u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .drv_active(drv_active), .drv_sda(drv_sda), .bit_idx(bit_idx),
        .addr_phase(addr_phase), .own_addr(own_addr), .gc_en(gc_en),
        .retry_en(retry_en), .sda_oe_req(sda_oe_req), .scl_oe_req(scl_oe_req),
        .sda_oe(sda_oe), .scl_oe(scl_oe), .arb_lost(arb_lost),
        .lost_in_addr(lost_in_addr), .status(status), .mode(mode),
        .start_req(start_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One bit: clock low with data set, then clock high; log enables at the rise.
    task automatic bit_cycle(input logic drv, input logic line, input int idx,
                             input logic aph, input logic act);
        @(negedge clk);
        scl_in = 1'b0; sda_in = line; drv_sda = drv;
        bit_idx = idx[3:0]; addr_phase = aph; drv_active = act;
        @(negedge clk);
        scl_in = 1'b1;
        #1;
        if (idx < 9) oe_log[idx] = sda_oe & scl_oe;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] winner, input logic [7:0] mine,
                             input logic aph);
        for (int i = 0; i < 8; i++) bit_cycle(mine[7-i], winner[7-i], i, aph, 1'b1);
        bit_cycle(1'b1, 1'b0, 8, aph, 1'b0);
    endtask

    task automatic bus_stop();
        @(negedge clk); scl_in = 1'b0; sda_in = 1'b0; drv_active = 1'b0;
        @(negedge clk); scl_in = 1'b1;
        @(negedge clk); sda_in = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 mode", mode, 0);
        chk("R1 status", status, 8'hF8);
        chk("R1 lost", arb_lost, 0);
        chk("R1 start_req", start_req, 0);
        chk("R1 oe follow", {sda_oe, scl_oe}, 2'b11);
    endtask

    task automatic t_same_bits();
        send_byte(8'hA4, 8'hA4, 1'b1);
        chk("R2 no loss", arb_lost, 0);
        chk("R2 mode", mode, 0);
        chk("R2 oe kept", oe_log[7:0], 8'hFF);
    endtask

    task automatic t_masked();
        bit_cycle(1'b1, 1'b0, 8, 1'b0, 1'b1);
        chk("R4 ack slot", arb_lost, 0);
        chk("R4 ack oe", oe_log[8], 1);
        bit_cycle(1'b1, 1'b0, 3, 1'b0, 1'b0);
        chk("R4 inactive", arb_lost, 0);
        chk("R4 inactive oe", {sda_oe, scl_oe}, 2'b11);
    endtask

    task automatic t_data_loss();
        retry_en = 1'b0;
        send_byte(8'h30, 8'h70, 1'b0);
        chk("R3 oe before", oe_log[0], 1);
        chk("R3 oe at conflict", oe_log[1], 0);
        chk("R3 oe held", {sda_oe, scl_oe}, 2'b00);
        chk("R5 lost", arb_lost, 1);
        chk("R5 in addr", lost_in_addr, 0);
        chk("R5 status", status, 8'h38);
        chk("R9 unaddressed", mode, 4);
        bus_stop();
        chk("R10 mode", mode, 0);
        chk("R10 status", status, 8'hF8);
        chk("R10 lost", arb_lost, 0);
        chk("R10 oe back", {sda_oe, scl_oe}, 2'b11);
    endtask

    task automatic t_addr(input string req, input logic [7:0] win, input logic [7:0] mine,
                          input logic gce, input logic rty, input int exp_st,
                          input int exp_md);
        gc_en = gce; retry_en = rty;
        send_byte(win, mine, 1'b1);
        chk({req, " status"}, status, exp_st);
        chk({req, " mode"}, mode, exp_md);
        chk({req, " in addr"}, lost_in_addr, 1);
        chk({req, " oe off"}, {sda_oe, scl_oe}, 2'b00);
    endtask

    task automatic t_wait_start();
        t_addr("R9 no match", 8'h40, 8'h42, 1'b1, 1'b1, 8'h38, 5);
        @(negedge clk); scl_in = 1'b0; sda_in = 1'b0;
        @(negedge clk); scl_in = 1'b1;
        @(negedge clk); sda_in = 1'b1;
        @(negedge clk);
        chk("R9 start_req", start_req, 1);
        chk("R9 mode master", mode, 0);
        @(negedge clk);
        chk("R9 one cycle", start_req, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; scl_in = 1'b1; sda_in = 1'b1; drv_active = 1'b0;
        drv_sda = 1'b1; addr_phase = 1'b0; bit_idx = '0; own_addr = 7'h2A;
        gc_en = 1'b1; retry_en = 1'b0; sda_oe_req = 1'b1; scl_oe_req = 1'b1;
        oe_log = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_same_bits();
        t_masked();
        bus_stop();
        t_data_loss();
        t_addr("R6 own write", 8'h54, 8'h5C, 1'b1, 1'b0, 8'h68, 2);
        bus_stop();
        t_addr("R8 own read", 8'h55, 8'h5D, 1'b1, 1'b0, 8'hB0, 3);
        bus_stop();
        t_addr("R7 gc write", 8'h00, 8'h80, 1'b1, 1'b0, 8'h78, 2);
        bus_stop();
        t_addr("R7 gc off", 8'h00, 8'h80, 1'b0, 1'b0, 8'h38, 4);
        bus_stop();
        t_addr("R11 rw bit", 8'h54, 8'h55, 1'b1, 1'b0, 8'h68, 2);
        bus_stop();
        t_wait_start();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule